// File: doc/BRIEF.md
# Nonvolatile Byte Store Read-Access Controller

This block sits between a CPU register port and a byte-wide nonvolatile memory array. Software sees three registers: a location register, a byte register and a control register. The control register carries a self-clearing read strobe, a write-busy bit and two sticky fault flags. To read, software loads the location and then sets the read strobe. The controller fetches the byte, puts it in the byte register and clears the strobe by itself. While this happens it holds a CPU stall output high for exactly two clock cycles, so the following instruction always finds valid data and never has to poll.

A write is started from the control register. It keeps the busy bit set for a configurable number of cycles and commits the byte register to the array in the last busy cycle. If software rewrites the location or byte register while the write is still busy, the write is abandoned, nothing reaches the array, and a sticky corruption flag is raised. If software asks for a read while a write is busy, the request is refused, the strobe stays clear and a sticky read-error flag is raised. Both flags are cleared by writing 1 to them.

The array itself is outside the block. It answers a read request with the addressed byte one clock later.

Top module: `eeacc_ctrl`

## Requirements
- R1: After reset the location, byte and control registers read as zero and `stall_o` is low.
- R2: Writing control bit 0 = 1 while no write is busy fetches the byte at the location register. That byte is readable from the byte register once the strobe has cleared.
- R3: Control bit 0 reads 1 for exactly the two cycles after the strobe-setting write, then returns to 0 with no software action.
- R4: `stall_o` is high in exactly those two cycles and low otherwise.
- R5: Writing control bit 1 = 1 with bit 0 = 0 while idle sets busy (control bit 1) for WR_CYCLES cycles. In the last busy cycle the byte register is stored at the location register.
- R6: Writing the location or byte register while busy aborts the write. Busy clears on the next cycle, the array location keeps its old value, and the corruption flag (control bit 3) is set.
- R7: A read request (control bit 0 = 1) while busy is ignored. The strobe and `stall_o` stay low, the byte register is unchanged, and the read-error flag (control bit 2) is set.
- R8: Writing 1 to control bit 2 or bit 3 clears that flag. Writing 0 leaves it set.
- R9: A control write with both bit 0 and bit 1 set while idle performs only the read. No write starts and busy stays 0.
- R10: Register select codes: 0 selects the location register, 1 the byte register, 2 the control register. Code 3 reads zero and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 location, 1 byte, 2 control) |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Read data of the selected register |
| stall_o | output | 1 | CPU stall while a read is in flight |
| mem_re_o | output | 1 | Array read request |
| mem_we_o | output | 1 | Array write commit |
| mem_addr_o | output | AW | Array location |
| mem_wdata_o | output | DW | Array write byte |
| mem_rdata_i | input | DW | Array read byte, valid the cycle after mem_re_o |

## Verification
Several properties are checked by the assertions on every cycle. The stall lasts exactly two cycles and ends with the strobe clear. A refused read leaves the strobe low and raises the error flag. An abort drops busy and sets the corruption flag. A read request and a write commit never reach the array together. Other behaviour can only be seen through the bench's scenarios and its cycle-accurate model: that the byte really comes from the addressed location, that the commit lands after exactly WR_CYCLES busy cycles, that an aborted location keeps its old contents, and that writing 0 to a flag leaves it set.

// File: rtl/eeacc_pkg.sv
package eeacc_pkg;
  typedef enum logic [1:0] {
    SEL_LOC  = 2'd0,
    SEL_BYTE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_CAPT  = 2'd2
  } rd_state_e;

  localparam int unsigned CB_RSTB = 0;
  localparam int unsigned CB_BUSY = 1;
  localparam int unsigned CB_RERR = 2;
  localparam int unsigned CB_CORR = 3;
endpackage

// File: rtl/eeacc_rd_seq.sv
module eeacc_rd_seq
  import eeacc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic mem_req_o,
  output logic capture_o
);
  rd_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RD_IDLE;
    else begin
      unique case (st_q)
        RD_IDLE:  if (start_i) st_q <= RD_ISSUE;
        RD_ISSUE: st_q <= RD_CAPT;
        RD_CAPT:  st_q <= RD_IDLE;
        default:  st_q <= RD_IDLE;
      endcase
    end
  end

  assign active_o  = (st_q != RD_IDLE);
  assign mem_req_o = (st_q == RD_ISSUE);
  assign capture_o = (st_q == RD_CAPT);

  // R4
  stall_second_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |=> active_o);
  // R4
  stall_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o)) |=> !active_o);
  // R3
  strobe_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !active_o);
endmodule

// File: rtl/eeacc_wr_track.sv
module eeacc_wr_track #(
  parameter int unsigned WR_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic commit_o
);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CW'(1)) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (busy_o) cnt_q <= abort_i ? '0 : cnt_q - CW'(1);
    else if (start_i) cnt_q <= CW'(WR_CYCLES);
  end

  // R5
  busy_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R6
  abort_drops_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && abort_i) |=> !busy_o);
  // R5
  commit_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_o);
endmodule

// File: rtl/eeacc_ctrl.sv
module eeacc_ctrl
  import eeacc_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned WR_CYCLES = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          stall_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [AW-1:0] loc_q;
  logic [DW-1:0] byte_q;
  logic          rerr_q, corr_q;
  logic          loc_we, byte_we, ctrl_we;
  logic          rd_start, rd_reject, wr_start, wr_abort;
  logic          rd_active, rd_capture, rd_req;
  logic          wr_busy, wr_commit;
  logic [DW-1:0] loc_ext, ctrl_rd;

  assign loc_we  = reg_we_i && (reg_sel_i == SEL_LOC);
  assign byte_we = reg_we_i && (reg_sel_i == SEL_BYTE);
  assign ctrl_we = reg_we_i && (reg_sel_i == SEL_CTRL);

  assign rd_start  = ctrl_we && reg_wdata_i[CB_RSTB] && !wr_busy && !rd_active;
  assign rd_reject = ctrl_we && reg_wdata_i[CB_RSTB] && wr_busy;
  // read wins when both request bits are set
  assign wr_start  = ctrl_we && reg_wdata_i[CB_BUSY] && !reg_wdata_i[CB_RSTB]
                     && !wr_busy && !rd_active;
  assign wr_abort  = (loc_we || byte_we) && wr_busy;

  eeacc_rd_seq u_rd_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (rd_start),
    .active_o  (rd_active),
    .mem_req_o (rd_req),
    .capture_o (rd_capture)
  );

  eeacc_wr_track #(.WR_CYCLES(WR_CYCLES)) u_wr_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wr_start),
    .abort_i  (wr_abort),
    .busy_o   (wr_busy),
    .commit_o (wr_commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_q  <= '0;
      byte_q <= '0;
      rerr_q <= 1'b0;
      corr_q <= 1'b0;
    end else begin
      if (loc_we) loc_q <= reg_wdata_i[AW-1:0];
      if (rd_capture) byte_q <= mem_rdata_i;
      else if (byte_we) byte_q <= reg_wdata_i;
      if (rd_reject) rerr_q <= 1'b1;
      else if (ctrl_we && reg_wdata_i[CB_RERR]) rerr_q <= 1'b0;
      if (wr_abort) corr_q <= 1'b1;
      else if (ctrl_we && reg_wdata_i[CB_CORR]) corr_q <= 1'b0;
    end
  end

  always_comb begin
    loc_ext = '0;
    loc_ext[AW-1:0] = loc_q;
    ctrl_rd = '0;
    ctrl_rd[CB_RSTB] = rd_active;
    ctrl_rd[CB_BUSY] = wr_busy;
    ctrl_rd[CB_RERR] = rerr_q;
    ctrl_rd[CB_CORR] = corr_q;
    unique case (reg_sel_i)
      SEL_LOC:  reg_rdata_o = loc_ext;
      SEL_BYTE: reg_rdata_o = byte_q;
      SEL_CTRL: reg_rdata_o = ctrl_rd;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign stall_o     = rd_active;
  assign mem_re_o    = rd_req;
  assign mem_we_o    = wr_commit;
  assign mem_addr_o  = loc_q;
  assign mem_wdata_o = byte_q;

  // R7
  reject_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_reject |=> (!stall_o && rerr_q));
  // R6
  abort_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_abort |=> (corr_q && !wr_busy));
  // R5
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  // R9
  both_bits_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && reg_wdata_i[CB_RSTB] && reg_wdata_i[CB_BUSY] && !wr_busy && !rd_active)
      |=> (stall_o && !wr_busy));
endmodule

// File: tb/eeacc_ctrl_test.sv
`timescale 1ns/1ps
module eeacc_ctrl_test;
  localparam int WR = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rdata;
  logic       stall, m_re, m_we;
  logic [7:0] m_addr, m_wd;
  logic [7:0] m_rd;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  eeacc_ctrl #(.AW(8), .DW(8), .WR_CYCLES(WR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .stall_o(stall),
    .mem_re_o(m_re), .mem_we_o(m_we), .mem_addr_o(m_addr),
    .mem_wdata_o(m_wd), .mem_rdata_i(m_rd)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // array behind the block
  logic [7:0] arr [256];
  initial for (int i = 0; i < 256; i++) arr[i] = init_val(i);
  always @(posedge clk) begin
    if (m_we) arr[m_addr] <= m_wd;
    if (m_re) m_rd <= arr[m_addr];
  end

  // behavioural reference
  int   r_loc, r_byte, r_buf, r_ph, r_cnt;
  bit   r_err, r_corr;
  int   r_mem [256];
  initial for (int i = 0; i < 256; i++) r_mem[i] = init_val(i);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_loc = 0; r_byte = 0; r_buf = 0; r_ph = 0; r_cnt = 0; r_err = 0; r_corr = 0;
    end else begin
      bit cw, lw, bw, busy, act, rs, rej, ws, ab, cap;
      cw = we && sel == 2; lw = we && sel == 0; bw = we && sel == 1;
      busy = r_cnt > 0; act = r_ph != 0;
      rs  = cw && wd[0] && !busy && !act;
      rej = cw && wd[0] && busy;
      ws  = cw && wd[1] && !wd[0] && !busy && !act;
      ab  = (lw || bw) && busy;
      cap = 0;
      if (busy) begin
        if (ab) begin r_cnt = 0; r_corr = 1; end
        else begin
          if (r_cnt == 1) r_mem[r_loc] = r_byte;
          r_cnt--;
        end
      end else if (ws) r_cnt = WR;
      if (r_ph == 1) begin r_buf = r_mem[r_loc]; r_ph = 2; end
      else if (r_ph == 2) begin cap = 1; r_ph = 0; end
      else if (rs) r_ph = 1;
      if (cap) r_byte = r_buf; else if (bw) r_byte = wd;
      if (lw) r_loc = wd;
      if (rej) r_err = 1; else if (cw && wd[2]) r_err = 0;
      if (ab) r_corr = 1; else if (cw && wd[3]) r_corr = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      int exp_rd;
      case (sel)
        2'd0: exp_rd = r_loc;
        2'd1: exp_rd = r_byte;
        2'd2: exp_rd = {r_corr, r_err, r_cnt > 0, r_ph != 0};
        default: exp_rd = 0;
      endcase
      chk("R2/R5 model rdata", rdata, exp_rd);
      chk("R4 model stall", stall, r_ph != 0);
    end
  end

  task automatic wr_reg(logic [1:0] s, logic [7:0] v);
    @(negedge clk); we = 1; sel = s; wd = v;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_reg(logic [1:0] s, output int v);
    sel = s; #0.5; v = rdata;
  endtask

  task automatic wait_idle();
    int v;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); rd_reg(2, v);
      if (v[1:0] == 0) break;
    end
  endtask

  task automatic do_read(logic [7:0] a, output int v);
    wr_reg(0, a); wr_reg(2, 8'h01);
    @(negedge clk); @(negedge clk); rd_reg(1, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd_reg(0, v); chk("R1 loc reset", v, 0);
    rd_reg(1, v); chk("R1 byte reset", v, 0);
    rd_reg(2, v); chk("R1 ctrl reset", v, 0);
    chk("R1 stall reset", stall, 0);

    // R2 R3 R4 read timing
    wr_reg(0, 8'h10);
    wr_reg(2, 8'h01);
    rd_reg(2, v); chk("R3 strobe cycle1", v & 1, 1); chk("R4 stall cycle1", stall, 1);
    @(negedge clk);
    rd_reg(2, v); chk("R3 strobe cycle2", v & 1, 1); chk("R4 stall cycle2", stall, 1);
    @(negedge clk);
    rd_reg(2, v); chk("R3 strobe cleared", v & 1, 0); chk("R4 stall released", stall, 0);
    rd_reg(1, v); chk("R2 read byte", v, init_val(16));

    // R10 register decode
    wr_reg(1, 8'h5A);
    rd_reg(1, v); chk("R10 byte sel", v, 8'h5A);
    rd_reg(0, v); chk("R10 loc sel", v, 8'h10);
    wr_reg(3, 8'hFF);
    rd_reg(3, v); chk("R10 sel3 zero", v, 0);
    rd_reg(0, v); chk("R10 sel3 write no effect loc", v, 8'h10);
    rd_reg(1, v); chk("R10 sel3 write no effect byte", v, 8'h5A);
    rd_reg(2, v); chk("R10 sel3 write no effect ctrl", v, 0);

    // R5 write with busy window
    wr_reg(0, 8'h20); wr_reg(1, 8'hC3); wr_reg(2, 8'h02);
    rd_reg(2, v); chk("R5 busy set", (v >> 1) & 1, 1);
    repeat (WR - 1) @(negedge clk);
    rd_reg(2, v); chk("R5 busy last cycle", (v >> 1) & 1, 1);
    @(negedge clk);
    rd_reg(2, v); chk("R5 busy cleared", (v >> 1) & 1, 0);
    do_read(8'h20, v); chk("R5 committed byte", v, 8'hC3);

    // R7 read while busy
    wr_reg(0, 8'h30); wr_reg(1, 8'h11); wr_reg(2, 8'h02);
    wr_reg(2, 8'h01);
    rd_reg(2, v); chk("R7 strobe stays clear", v & 1, 0);
    chk("R7 no stall", stall, 0);
    chk("R7 error flag", (v >> 2) & 1, 1);
    rd_reg(1, v); chk("R7 byte unchanged", v, 8'h11);
    wait_idle();
    // R8 flag clearing
    wr_reg(2, 8'h00);
    rd_reg(2, v); chk("R8 write 0 keeps err", (v >> 2) & 1, 1);
    wr_reg(2, 8'h04);
    rd_reg(2, v); chk("R8 write 1 clears err", (v >> 2) & 1, 0);

    // R6 abort
    wr_reg(0, 8'h40); wr_reg(1, 8'h99); wr_reg(2, 8'h02);
    @(negedge clk);
    wr_reg(0, 8'h40);
    rd_reg(2, v); chk("R6 busy dropped", (v >> 1) & 1, 0);
    chk("R6 corrupt flag", (v >> 3) & 1, 1);
    repeat (WR) @(negedge clk);
    do_read(8'h40, v); chk("R6 array untouched", v, init_val(64));
    wr_reg(2, 8'h00);
    rd_reg(2, v); chk("R8 write 0 keeps corr", (v >> 3) & 1, 1);
    wr_reg(2, 8'h08);
    rd_reg(2, v); chk("R8 write 1 clears corr", (v >> 3) & 1, 0);

    // R9 both request bits
    wr_reg(0, 8'h55); wr_reg(2, 8'h03);
    rd_reg(2, v); chk("R9 read runs", v & 3, 1);
    @(negedge clk); @(negedge clk);
    rd_reg(2, v); chk("R9 no write started", (v >> 1) & 1, 0);
    rd_reg(1, v); chk("R9 read byte", v, init_val(85));

    // mixed traffic checked by the reference each clock
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      we  = ($urandom_range(0, 2) != 0);
      sel = 2'($urandom_range(0, 3));
      wd  = 8'($urandom_range(0, 255));
    end
    @(negedge clk); we = 0;
    repeat (20) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule